// File: doc/BRIEF.md
# Configurable Framing UART Receiver

This block turns an asynchronous serial line back into parallel characters. An external baud generator supplies a single-cycle tick at sixteen times the bit rate. The receiver uses that tick to find the start bit, confirm it, and sample every later bit at its centre. The character format comes from the same six-bit line-control value that configures the matching transmitter. That value sets the word length, the parity scheme and the stop-bit setting. The receiver latches it when it confirms a start bit, so a change in the middle of a character takes effect only from the next one.

Each completed character is placed right-justified in a buffer, with zeros above the last data bit. Status flags accompany the character: data ready, parity error, framing error, break and overrun. A one-cycle read strobe takes the character from the buffer and clears the data-ready and overrun flags.

Top module: `lcr_uart_rx`

## Requirements
- R1: Line-control bits [1:0] select the word length (00 = 5, 01 = 6, 10 = 7, 11 = 8 data bits). Data bits arrive LSB first and are placed right-justified in `data_o`, with the unused upper bits at 0.
- R2: A low line seen on a tick is re-sampled 8 ticks later. If the line is high at that point, the event is a false start: no character is produced and no flag changes.
- R3: After the start bit is confirmed, every following bit is sampled once every 16 ticks, at the centre of the bit.
- R4: With bit 3 = 1 and bit 5 = 0, a parity bit follows the last data bit. Bit 4 = 0 selects odd parity and bit 4 = 1 selects even parity, counted over the data bits plus the parity bit. `parity_err_o` shows a mismatch.
- R5: With bits 3 and 5 both 1, the parity bit must be the constant NOT bit 4 (0 when bit 4 = 1, 1 when bit 4 = 0). Otherwise `parity_err_o` is set.
- R6: Only the first stop bit is sampled, and bit 2 has no effect on reception. `frame_err_o` is 1 when that stop bit is 0.
- R7: `break_o` is 1 when every data bit, the parity bit (if enabled) and the stop bit of a character are all 0.
- R8: `ready_o` is set when a character completes and cleared by `rd_i`. The status flags describe the character held in the buffer.
- R9: `overrun_o` is set when a character completes while `ready_o` is still 1 and no read occurs in that cycle. A read clears it.
- R10: After reset all outputs are 0.
- R11: With bit 3 = 0 no parity bit is expected, and `parity_err_o` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rxd_i | input | 1 | Serial input line, idle high |
| tick_i | input | 1 | Oversampling tick, 16 per bit |
| line_ctrl_i | input | 6 | Line control: [1:0] length, [2] stop setting, [3] parity enable, [4] even select, [5] stick |
| rd_i | input | 1 | Buffer read strobe |
| data_o | output | 8 | Received character, right-justified |
| ready_o | output | 1 | Character available |
| parity_err_o | output | 1 | Parity mismatch on buffered character |
| frame_err_o | output | 1 | First stop bit sampled low |
| break_o | output | 1 | All-zero frame including stop bit |
| overrun_o | output | 1 | Unread character was overwritten |

## Verification
The bench builds the block with its default 16-tick oversampling and a two-stage input synchronizer. It drives one tick every second clock, which gives each bit 32 clocks of margin around the sampling point. With these settings, every combination of the four word lengths, five parity schemes and both stop settings can be swept with several data patterns each. Further frames target corrupted parity, a low stop bit, a break, a short glitch and two characters arriving without a read.

// File: rtl/lcr_rx_pkg.sv
package lcr_rx_pkg;
  typedef enum logic [2:0] {ST_IDLE, ST_START, ST_DATA, ST_PAR, ST_STOP} rx_state_e;

  typedef struct packed {
    logic       par_stick;
    logic       par_even;
    logic       par_en;
    logic [1:0] wlen;
  } line_cfg_t;
endpackage

// File: rtl/lcr_rx_sync.sv
module lcr_rx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] ff_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ff_q <= '1;
    else         ff_q <= {ff_q[STAGES-2:0], d_i};
  end

  assign q_o = ff_q[STAGES-1];
endmodule

// File: rtl/lcr_rx_frame.sv
module lcr_rx_frame
  import lcr_rx_pkg::*;
#(
  parameter int OVERSAMPLE = 16,
  parameter int DATA_W     = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              rxd_i,
  input  line_cfg_t         cfg_i,
  output logic              done_o,
  output logic [DATA_W-1:0] data_o,
  output logic              perr_o,
  output logic              ferr_o,
  output logic              brk_o
);
  localparam int CNT_W = $clog2(OVERSAMPLE);
  localparam int IDX_W = $clog2(DATA_W);
  localparam logic [CNT_W-1:0] HALF_M1 = CNT_W'(OVERSAMPLE / 2 - 1);
  localparam logic [CNT_W-1:0] FULL_M1 = CNT_W'(OVERSAMPLE - 1);

  rx_state_e         state_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [IDX_W-1:0]  idx_q;
  logic [DATA_W-1:0] shreg_q;
  logic              par_q, zero_q;
  line_cfg_t         cfg_q;

  logic [IDX_W-1:0]  last_idx;
  logic [IDX_W-1:0]  shamt;
  logic              mid_bit, ones_odd, perr_d;

  assign last_idx = IDX_W'(4) + IDX_W'(cfg_q.wlen);
  assign shamt    = IDX_W'(3) - IDX_W'(cfg_q.wlen);
  assign mid_bit  = tick_i && (cnt_q == FULL_M1);
  assign ones_odd = (^shreg_q) ^ par_q;

  always_comb begin
    if (!cfg_q.par_en)         perr_d = 1'b0;
    else if (cfg_q.par_stick)  perr_d = (par_q == cfg_q.par_even);
    else if (cfg_q.par_even)   perr_d = ones_odd;
    else                       perr_d = ~ones_odd;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      idx_q   <= '0;
      shreg_q <= '0;
      par_q   <= 1'b0;
      zero_q  <= 1'b0;
      cfg_q   <= '0;
      done_o  <= 1'b0;
      data_o  <= '0;
      perr_o  <= 1'b0;
      ferr_o  <= 1'b0;
      brk_o   <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (tick_i && state_q != ST_IDLE && !mid_bit && !(state_q == ST_START && cnt_q == HALF_M1))
        cnt_q <= cnt_q + 1'b1;
      unique case (state_q)
        ST_IDLE: if (tick_i && !rxd_i) begin
          state_q <= ST_START;
          cnt_q   <= '0;
          cfg_q   <= cfg_i;
        end
        ST_START: if (tick_i && cnt_q == HALF_M1) begin
          cnt_q <= '0;
          if (rxd_i) state_q <= ST_IDLE;  // false start
          else begin
            state_q <= ST_DATA;
            idx_q   <= '0;
            shreg_q <= '0;
            par_q   <= 1'b0;
            zero_q  <= 1'b1;
          end
        end
        ST_DATA: if (mid_bit) begin
          cnt_q   <= '0;
          shreg_q <= {rxd_i, shreg_q[DATA_W-1:1]};
          zero_q  <= zero_q & ~rxd_i;
          idx_q   <= idx_q + 1'b1;
          if (idx_q == last_idx) state_q <= cfg_q.par_en ? ST_PAR : ST_STOP;
        end
        ST_PAR: if (mid_bit) begin
          cnt_q   <= '0;
          par_q   <= rxd_i;
          zero_q  <= zero_q & ~rxd_i;
          state_q <= ST_STOP;
        end
        ST_STOP: if (mid_bit) begin
          cnt_q   <= '0;
          state_q <= ST_IDLE;
          done_o  <= 1'b1;
          data_o  <= shreg_q >> shamt;
          perr_o  <= perr_d;
          ferr_o  <= ~rxd_i;
          brk_o   <= zero_q & ~rxd_i;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  p_false_start_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_START && tick_i && cnt_q == HALF_M1 && rxd_i) |=> (state_q == ST_IDLE && !done_o));

  p_break_is_framing_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && brk_o) |-> ferr_o);

  p_zero_fill_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && cfg_q.wlen == 2'b00) |-> (data_o[DATA_W-1:5] == '0));

  p_no_parity_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !cfg_q.par_en) |-> !perr_o);
endmodule

// File: rtl/lcr_rx_status.sv
module lcr_rx_status #(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              done_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              perr_i,
  input  logic              ferr_i,
  input  logic              brk_i,
  input  logic              rd_i,
  output logic [DATA_W-1:0] data_o,
  output logic              ready_o,
  output logic              perr_o,
  output logic              ferr_o,
  output logic              brk_o,
  output logic              overrun_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_o    <= '0;
      ready_o   <= 1'b0;
      perr_o    <= 1'b0;
      ferr_o    <= 1'b0;
      brk_o     <= 1'b0;
      overrun_o <= 1'b0;
    end else if (done_i) begin
      data_o    <= data_i;
      ready_o   <= 1'b1;
      perr_o    <= perr_i;
      ferr_o    <= ferr_i;
      brk_o     <= brk_i;
      overrun_o <= (ready_o && !rd_i) || (overrun_o && !rd_i);
    end else if (rd_i) begin
      ready_o   <= 1'b0;
      overrun_o <= 1'b0;
    end
  end

  p_ready_set_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |=> ready_o);

  p_read_clear_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && !done_i) |=> (!ready_o && !overrun_o));

  p_overrun_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_i && ready_o && !rd_i) |=> overrun_o);
endmodule

// File: rtl/lcr_uart_rx.sv
module lcr_uart_rx
  import lcr_rx_pkg::*;
#(
  parameter int OVERSAMPLE  = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       rxd_i,
  input  logic       tick_i,
  input  logic [5:0] line_ctrl_i,
  input  logic       rd_i,
  output logic [7:0] data_o,
  output logic       ready_o,
  output logic       parity_err_o,
  output logic       frame_err_o,
  output logic       break_o,
  output logic       overrun_o
);
  localparam int DATA_W = 8;

  logic              rxd_s, done;
  logic [DATA_W-1:0] frm_data;
  logic              frm_perr, frm_ferr, frm_brk;
  line_cfg_t         cfg;
  logic              unused_stop_sel;

  // stop-bit setting only matters to the transmitter
  assign unused_stop_sel = line_ctrl_i[2];
  assign cfg = line_cfg_t'({line_ctrl_i[5:3], line_ctrl_i[1:0]});

  lcr_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (rxd_i),
    .q_o   (rxd_s)
  );

  lcr_rx_frame #(.OVERSAMPLE(OVERSAMPLE), .DATA_W(DATA_W)) u_frame (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .tick_i(tick_i),
    .rxd_i (rxd_s),
    .cfg_i (cfg),
    .done_o(done),
    .data_o(frm_data),
    .perr_o(frm_perr),
    .ferr_o(frm_ferr),
    .brk_o (frm_brk)
  );

  lcr_rx_status #(.DATA_W(DATA_W)) u_status (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .done_i   (done),
    .data_i   (frm_data),
    .perr_i   (frm_perr),
    .ferr_i   (frm_ferr),
    .brk_i    (frm_brk),
    .rd_i     (rd_i),
    .data_o   (data_o),
    .ready_o  (ready_o),
    .perr_o   (parity_err_o),
    .ferr_o   (frame_err_o),
    .brk_o    (break_o),
    .overrun_o(overrun_o)
  );
endmodule

// File: tb/lcr_uart_rx_tb_top.sv
module lcr_uart_rx_tb_top;
  localparam int BIT_CLKS = 32;  // 16 ticks, one tick every 2 clocks

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       rxd_i = 1'b1;
  logic       tick_i = 1'b0;
  logic [5:0] line_ctrl_i = '0;
  logic       rd_i = 1'b0;
  logic [7:0] data_o;
  logic       ready_o, parity_err_o, frame_err_o, break_o, overrun_o;

  int n_chk = 0;
  int n_bad = 0;

  lcr_uart_rx dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .rxd_i(rxd_i), .tick_i(tick_i),
    .line_ctrl_i(line_ctrl_i), .rd_i(rd_i), .data_o(data_o), .ready_o(ready_o),
    .parity_err_o(parity_err_o), .frame_err_o(frame_err_o), .break_o(break_o),
    .overrun_o(overrun_o)
  );

  always #4 clk_i = ~clk_i;

  initial begin
    forever begin
      @(negedge clk_i);
      tick_i = ~tick_i;
    end
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    n_chk++; n_bad++;
    $display("FAIL watchdog: run did not complete, got=timeout exp=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  function automatic logic [12:0] outs();
    return {ready_o, overrun_o, break_o, frame_err_o, parity_err_o, data_o};
  endfunction

  task automatic chk(input string tag, input logic [12:0] got, input logic [12:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got=%h exp=%h (rdy ovr brk ferr perr data)", tag, got, exp);
    end
  endtask

  task automatic send_bit(input logic b);
    rxd_i = b;
    repeat (BIT_CLKS) @(negedge clk_i);
  endtask

  task automatic do_read();
    rd_i = 1'b1;
    @(negedge clk_i);
    rd_i = 1'b0;
    @(negedge clk_i);
  endtask

  // sends one frame and returns expected status vector (ready=1, overrun=0)
  task automatic send_frame(input logic [5:0] lc, input logic [7:0] d, input logic flip,
                            input logic stop_v, output logic [12:0] exp);
    int nb;
    logic [7:0] dm;
    logic par;
    nb = 5 + int'(lc[1:0]);
    dm = d & 8'((1 << nb) - 1);
    if (lc[5]) par = ~lc[4];
    else       par = lc[4] ? ^dm : ~^dm;
    par = par ^ flip;
    line_ctrl_i = lc;
    send_bit(1'b0);
    for (int i = 0; i < nb; i++) send_bit(dm[i]);
    if (lc[3]) send_bit(par);
    send_bit(stop_v);
    if (lc[2] && stop_v) send_bit(1'b1);
    send_bit(1'b1);
    exp = {1'b1, 1'b0,
           (dm == 8'h00) && !(lc[3] && par) && !stop_v,
           !stop_v,
           lc[3] && flip,
           dm};
  endtask

  initial begin
    logic [12:0] e, e2;
    repeat (5) @(negedge clk_i);
    chk("R10 reset", outs(), 13'h0);
    rst_ni = 1'b1;
    repeat (40) @(negedge clk_i);
    chk("R10 idle after reset", outs(), 13'h0);

    // sweep: length x parity scheme x pattern (stop setting alternates)
    for (int wl = 0; wl < 4; wl++) begin
      for (int md = 0; md < 5; md++) begin
        for (int k = 0; k < 4; k++) begin
          logic [5:0] lc;
          logic [7:0] d;
          logic flip;
          string tag;
          case (md)
            0: begin lc = 6'b000000; tag = "R1 R3 R11 no parity"; end
            1: begin lc = 6'b001000; tag = "R4 odd parity"; end
            2: begin lc = 6'b011000; tag = "R4 even parity"; end
            3: begin lc = 6'b111000; tag = "R5 stick zero"; end
            default: begin lc = 6'b101000; tag = "R5 stick one"; end
          endcase
          lc[1:0] = 2'(wl);
          lc[2]   = k[0];  // R6: stop setting must not matter
          case (k)
            0: d = 8'hFF;
            1: d = 8'h5A;
            2: d = 8'h81;
            default: d = 8'(37 * wl + 11 * md + 3);
          endcase
          flip = (k == 3) || (k == 1 && md >= 3);
          send_frame(lc, d, flip, 1'b1, e);
          chk(tag, outs(), e);
          do_read();
          chk("R8 read clears ready", {ready_o, overrun_o}, 2'b00);
        end
      end
    end

    // framing error: stop bit low, data nonzero
    send_frame(6'b000011, 8'h55, 1'b0, 1'b0, e);
    send_bit(1'b1);
    chk("R6 framing error", outs(), e);
    do_read();

    // break: all zero with parity (stick 0) and stop low
    send_frame(6'b111011, 8'h00, 1'b0, 1'b0, e);
    send_bit(1'b1);
    chk("R7 break with parity", outs(), e);
    do_read();
    send_frame(6'b000001, 8'h00, 1'b0, 1'b0, e);
    send_bit(1'b1);
    chk("R7 break no parity", outs(), e);
    do_read();

    // zero data but stop high: no break
    send_frame(6'b000011, 8'h00, 1'b0, 1'b1, e);
    chk("R7 zero data not break", outs(), e);
    do_read();

    // false start glitch: 3 ticks low
    line_ctrl_i = 6'b000011;
    rxd_i = 1'b0;
    repeat (6) @(negedge clk_i);
    rxd_i = 1'b1;
    repeat (3 * BIT_CLKS) @(negedge clk_i);
    chk("R2 false start ignored", outs(), {5'b00000, 8'h00});
    send_frame(6'b000011, 8'hC3, 1'b0, 1'b1, e);
    chk("R2 frame after glitch", outs(), e);
    do_read();

    // overrun: two frames, no read between
    send_frame(6'b000011, 8'h12, 1'b0, 1'b1, e);
    chk("R9 first frame", outs(), e);
    send_frame(6'b011010, 8'h6B, 1'b0, 1'b1, e2);
    e2[11] = 1'b1;
    chk("R9 overrun set", outs(), e2);
    do_read();
    chk("R9 read clears overrun", {ready_o, overrun_o}, 2'b00);

    // 5-bit word with upper bits set in the source byte
    send_frame(6'b000000, 8'hFF, 1'b0, 1'b1, e);
    chk("R1 zero fill", outs(), {5'b10000, 8'h1F});
    do_read();

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule